// File: doc/BRIEF.md
# Timeslot Transmit Collision Detector

This block sits beside a multi-channel serial voice interface. Each channel has a transmit enable, a highway select and a timeslot index. Every cycle the block compares all pairs of channels. Two enabled transmitters that name the same highway and the same timeslot are in collision. The block then blocks their transmit enables and raises a sticky crash flag. Channels outside the collision keep sending.

Software sees a status byte. The crash flag and the set of blocked channels are held until two things have happened: the assignments no longer conflict, and the status byte has been read. A read made while the conflict still exists clears nothing. When the flag does clear, the blocked channels are released at that same clock edge. The block produces only the per-channel transmit gates; it does no serial shifting.

Status byte layout: bits [1:0] hold the version code, bit 2 is the sticky crash flag, bit 3 is the live conflict indication, and bits [7:4] are the blocked-channel mask (bit 4+i is channel i).

Top module: `tx_slot_guard`

## Requirements
- R1: After reset the crash flag and blocked mask are zero, and the status byte reads 0x01.
- R2: When two or more enabled channels share a highway and a timeslot, the crash flag (status bit 2) is set at the next rising clock edge.
- R3: A disabled channel never takes part in a collision, even if its highway and timeslot match another channel.
- R4: Channels with equal timeslots but different highway selects do not collide.
- R5: A colliding channel's tx_gate is low in the same cycle the conflict appears, and it stays low while its bit in the blocked mask is set.
- R6: A channel that is not colliding and not blocked has tx_gate equal to its tx_en.
- R7: A status read while any conflict is live leaves the crash flag and the blocked mask set.
- R8: Once the conflict is removed, the crash flag and blocked mask stay set until a status read. The read clears both at its clock edge, and tx_gate is released in the same cycle.
- R9: Status bits [1:0] always read 01.
- R10: Status bits [7:4] show the blocked channels, and bit 3 shows whether a conflict exists in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | NCH | Per-channel transmit enable |
| hw_sel | input | NCH*HW_W | Per-channel highway select, channel i at [i*HW_W +: HW_W] |
| ts_idx | input | NCH*TS_W | Per-channel timeslot index, channel i at [i*TS_W +: TS_W] |
| stat_rd | input | 1 | Status read strobe, one cycle |
| stat_byte | output | 8 | Status byte |
| tx_gate | output | NCH | Gated per-channel transmit enable |

## Verification
The bench uses the default parameters: four channels, a one-bit highway select and five-bit timeslots. Four channels give six pairs, so a pairwise collision, a three-way collision and a collision on the second highway can all be driven. The one-bit highway lets equal timeslots on different highways be checked apart from a real clash. A five-bit timeslot leaves room to move a channel away and clear the conflict while its blocked bit is still held.

// File: rtl/tx_slot_guard.sv
module tx_slot_guard #(
  parameter int NCH = 4,
  parameter int HW_W = 1,
  parameter int TS_W = 5,
  parameter logic [1:0] VERSION = 2'b01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       tx_en,
  input  logic [NCH*HW_W-1:0]  hw_sel,
  input  logic [NCH*TS_W-1:0]  ts_idx,
  input  logic                 stat_rd,
  output logic [7:0]           stat_byte,
  output logic [NCH-1:0]       tx_gate
);
  localparam int MW = (NCH < 4) ? NCH : 4;

  logic [NCH-1:0] clash;
  logic [NCH-1:0] blk_q;
  logic           crash_q;
  logic           live;
  logic           clear_now;
  logic [3:0]     mask4;

  always_comb begin
    clash = '0;
    for (int i = 0; i < NCH; i++)
      for (int j = 0; j < NCH; j++)
        if (i != j && tx_en[i] && tx_en[j] &&
            hw_sel[i*HW_W +: HW_W] == hw_sel[j*HW_W +: HW_W] &&
            ts_idx[i*TS_W +: TS_W] == ts_idx[j*TS_W +: TS_W])
          clash[i] = 1'b1;
  end

  assign live      = |clash;
  assign clear_now = crash_q && stat_rd && !live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crash_q <= 1'b0;
      blk_q   <= '0;
    end else if (clear_now) begin
      crash_q <= 1'b0;
      blk_q   <= '0;
    end else begin
      crash_q <= crash_q | live;
      blk_q   <= blk_q | clash;
    end
  end

  assign tx_gate = tx_en & ~(blk_q | clash);

  always_comb begin
    mask4 = '0;
    mask4[MW-1:0] = blk_q[MW-1:0];
  end

  assign stat_byte = {mask4, live, crash_q, VERSION};

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> stat_byte[2]);

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !stat_rd) |=> ((tx_gate & $past(clash)) == '0));

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[2] && stat_rd && live) |=> (stat_byte[2] && blk_q != '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[2] && !stat_rd) |=> stat_byte[2]);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[2] && stat_rd && !live) |=> (!stat_byte[2] && tx_gate == (tx_en & ~clash)));

  always_comb
    if (rst_n) assert_version_R9: assert (stat_byte[1:0] == 2'b01);
endmodule

// File: tb/tb_tx_slot_guard.sv
module tb_tx_slot_guard;
  localparam int CLK = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_en = '0;
  logic [3:0] hw_sel = '0;
  logic [19:0] ts_idx = '0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_byte;
  logic [3:0] tx_gate;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] g;
    logic [7:0] s;
    string      tag;
  } item_t;

  item_t q[$];
  event ev;

  always #(CLK/2) clk = ~clk;

  tx_slot_guard dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .hw_sel(hw_sel),
    .ts_idx(ts_idx), .stat_rd(stat_rd), .stat_byte(stat_byte), .tx_gate(tx_gate)
  );

  function automatic logic [19:0] pk(int t3, int t2, int t1, int t0);
    return {5'(t3), 5'(t2), 5'(t1), 5'(t0)};
  endfunction

  task automatic step(input logic [3:0] en, input logic [3:0] hw, input logic [19:0] ts,
                      input logic rd, input logic [3:0] eg, input logic [7:0] es, input string tag);
    item_t it;
    @(negedge clk);
    tx_en = en; hw_sel = hw; ts_idx = ts; stat_rd = rd;
    #1;
    it.g = eg; it.s = es; it.tag = tag;
    q.push_back(it);
    -> ev;
  endtask

  initial begin
    forever begin
      item_t it;
      @(ev);
      while (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (tx_gate !== it.g || stat_byte !== it.s) begin
          bad++;
          $display("FAIL %s: gate=%b stat=%h expected gate=%b stat=%h",
                   it.tag, tx_gate, stat_byte, it.g, it.s);
        end
      end
    end
  end

  initial begin
    #(CLK*5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    step(4'b0000, 4'b0000, pk(0,0,0,0), 0, 4'b0000, 8'h01, "R1 reset state, R9 version");
    step(4'b1111, 4'b0000, pk(3,2,1,0), 0, 4'b1111, 8'h01, "R6 distinct slots pass");
    step(4'b1110, 4'b0000, pk(3,2,1,1), 0, 4'b1110, 8'h01, "R3 disabled channel no clash");
    step(4'b1110, 4'b0000, pk(3,2,1,1), 0, 4'b1110, 8'h01, "R3 no crash latched");
    step(4'b1111, 4'b0001, pk(3,2,1,1), 0, 4'b1111, 8'h01, "R4 other highway no clash");
    step(4'b1111, 4'b0001, pk(3,2,1,1), 0, 4'b1111, 8'h01, "R4 no crash latched");
    step(4'b1111, 4'b0000, pk(3,2,5,5), 0, 4'b1100, 8'h09, "R5 immediate gating, R6 others pass");
    step(4'b1111, 4'b0000, pk(3,2,5,5), 0, 4'b1100, 8'h3D, "R2 crash set, R10 mask");
    step(4'b1111, 4'b0000, pk(3,2,5,5), 1, 4'b1100, 8'h3D, "R7 read during conflict");
    step(4'b1111, 4'b0000, pk(3,2,5,5), 0, 4'b1100, 8'h3D, "R7 crash kept after read");
    step(4'b1111, 4'b0000, pk(3,2,6,5), 0, 4'b1100, 8'h35, "R8 corrected, still sticky");
    step(4'b1111, 4'b0000, pk(3,2,6,5), 0, 4'b1100, 8'h35, "R8 sticky without read");
    step(4'b1111, 4'b0000, pk(3,2,6,5), 1, 4'b1100, 8'h35, "R8 read after correction");
    step(4'b1111, 4'b0000, pk(3,2,6,5), 0, 4'b1111, 8'h01, "R8 cleared and released");
    step(4'b1111, 4'b0111, pk(7,7,7,7), 0, 4'b1000, 8'h09, "R5 three-way clash on highway 1");
    step(4'b1111, 4'b0111, pk(7,7,7,7), 0, 4'b1000, 8'h7D, "R2 R10 three-way latched");
    step(4'b1111, 4'b0111, pk(7,9,7,7), 1, 4'b1000, 8'h7D, "R7 read with partial conflict");
    step(4'b1111, 4'b0111, pk(7,9,8,7), 0, 4'b1000, 8'h75, "R8 all fixed, still held");
    step(4'b1111, 4'b0111, pk(7,9,8,7), 1, 4'b1000, 8'h75, "R8 clearing read");
    step(4'b1111, 4'b0111, pk(7,9,8,7), 0, 4'b1111, 8'h01, "R8 R9 released, version intact");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule